// File: doc/BRIEF.md
# Low-Supply Reset Sequencer

This block produces the active-low reset that a host processor sees. Its inputs are the supply condition and any other reset request. Four comparator flags arrive as digital inputs, one for each trip level. A 2-bit trip-select field, held in a control register, picks which flag counts. The selected flag is synchronized. While it reports an undervoltage, reset stays asserted. Once the supply is good again, reset is held for a further fixed number of ticks of a slow timebase, which by default is 100 ticks of a 1 ms enable. Any new undervoltage during that count starts it again. The same sequence applies at power-up.

Other reset sources, such as a watchdog timeout, are merged into the same output. The block also tells the register-access front end when the bus is locked. While reset is asserted, a new access is refused. An access that was accepted while the supply was healthy is tracked as in flight until it completes. A one-cycle pulse marks each release of reset, so that other logic can restart on it.

Top module: `lsr_seq`

## Requirements
- R1: While `rst` is high, `rst_n_o` is 0, `bus_lock` is 1, `rel_pulse` is 0 and `acc_inflight` is 0.
- R2: `trip_sel` code k (0 to 3) selects `below_flags[k]`: code 0 is 2.6 V, code 1 is 2.9 V, code 2 is 3.9 V and code 3 is 4.4 V. Flags that are not selected have no effect on `rst_n_o`.
- R3: A selected flag that goes to 1 before clock edge 1 drives `rst_n_o` to 0 after edge 4, and not earlier. This latency is made of two synchronizer stages, the hold state and the output register.
- R4: When the selected flag returns to 0 before edge 1 and `tick_1ms` is held at 1, `rst_n_o` goes to 1 after edge HOLD_TICKS+3, which is edge 103 by default.
- R5: The post-recovery hold advances only on cycles where `tick_1ms` is 1. With no ticks, reset stays asserted indefinitely.
- R6: An undervoltage seen during the hold count clears the count, so the full hold is measured again from the next recovery.
- R7: After `rst` is released with the supply good, the same hold applies: `rst_n_o` goes to 1 after edge 103 from release, given continuous ticks.
- R8: `ext_rst_req` = 1 before an edge drives `rst_n_o` to 0 after that edge. When the request drops, and there is no supply fault and no hold pending, `rst_n_o` returns to 1 after the next edge with no added stretch.
- R9: `rel_pulse` is 1 for exactly the one cycle in which `rst_n_o` has just gone from 0 to 1.
- R10: `bus_lock` is the complement of `rst_n_o`. An `acc_start` seen while `bus_lock` is 1 does not set `acc_inflight`.
- R11: An `acc_start` seen while `bus_lock` is 0 sets `acc_inflight` after the edge. It stays 1 through a later lockout until `acc_done` is sampled high. `acc_done` takes priority over `acc_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power-up) |
| tick_1ms | input | 1 | Timebase enable, one cycle per tick |
| below_flags | input | 4 | Comparator flags, 1 = supply below that level |
| trip_sel | input | 2 | Trip-level select field from the control register |
| ext_rst_req | input | 1 | External reset request, active high |
| acc_start | input | 1 | Register access begins (one-cycle pulse) |
| acc_done | input | 1 | Register access ends (one-cycle pulse) |
| rst_n_o | output | 1 | Processor reset, active low, registered |
| bus_lock | output | 1 | New bus accesses refused |
| rel_pulse | output | 1 | One-cycle pulse on reset release |
| acc_inflight | output | 1 | An accepted access is still completing |

## Verification
The assertions assume three things about the inputs. `trip_sel` is a register field that stays quiet while a fault is being resolved. `acc_start` and `acc_done` are single-cycle pulses. The comparator flags may change at any cycle, because they pass through the synchronizer. The stimulus respects this. It changes `trip_sel` only at vector boundaries, followed by a settle period longer than the full hold. It drives every access strobe for exactly one cycle, and it sets all inputs on the falling clock edge.

// File: rtl/lsr_pkg.sv
package lsr_pkg;
  localparam int LVL_N = 4;
  localparam int SEL_W = $clog2(LVL_N);
  typedef logic [LVL_N-1:0] lvl_vec_t;
  typedef logic [SEL_W-1:0] lvl_sel_t;
endpackage

// File: rtl/lsr_sync.sv
module lsr_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= {WIDTH{RST_VAL}};
    else     stg[0] <= d;
  end

  genvar i;
  generate
    for (i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stg[i] <= {WIDTH{RST_VAL}};
        else     stg[i] <= stg[i-1];
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/lsr_level_pick.sv
module lsr_level_pick
  import lsr_pkg::*;
(
  input  lvl_vec_t flags_s,
  input  lvl_sel_t sel,
  output logic     fault
);
  always_comb begin
    fault = 1'b0;
    for (int k = 0; k < LVL_N; k++) begin
      if (sel == lvl_sel_t'(k)) fault = flags_s[k];
    end
  end
endmodule

// File: rtl/lsr_hold_timer.sv
module lsr_hold_timer #(
  parameter int HOLD_TICKS = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic fault,
  input  logic tick,
  output logic hold
);
  localparam int CNT_W = $clog2(HOLD_TICKS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_TICKS - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || fault) begin
      cnt  <= '0;
      hold <= 1'b1;
    end else if (hold && tick) begin
      if (cnt == LAST) begin
        cnt  <= '0;
        hold <= 1'b0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R4: count never passes its terminal value
  p_cnt_range_r4: assert property (@(posedge clk) disable iff (rst)
    cnt < CNT_W'(HOLD_TICKS));
  // R4/R5: release only after the last tick of the count
  p_release_after_count_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(hold) |-> ($past(cnt) == LAST && $past(tick)));
  // R6: a fault restarts the hold
  p_fault_restart_r6: assert property (@(posedge clk) disable iff (rst)
    fault |=> (hold && cnt == '0));
endmodule

// File: rtl/lsr_bus_guard.sv
module lsr_bus_guard (
  input  logic clk,
  input  logic rst,
  input  logic locked,
  input  logic start,
  input  logic done,
  output logic inflight
);
  always_ff @(posedge clk) begin
    if (rst)                   inflight <= 1'b0;
    else if (done)             inflight <= 1'b0;
    else if (start && !locked) inflight <= 1'b1;
  end

  // R10: no new access accepted while locked
  p_no_new_when_locked_r10: assert property (@(posedge clk) disable iff (rst)
    (locked && !inflight) |=> !inflight);
  // R11: an accepted access survives until done
  p_inflight_kept_r11: assert property (@(posedge clk) disable iff (rst)
    (inflight && !done) |=> inflight);
endmodule

// File: rtl/lsr_seq.sv
module lsr_seq
  import lsr_pkg::*;
#(
  parameter int HOLD_TICKS  = 100,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_1ms,
  input  logic [LVL_N-1:0] below_flags,
  input  logic [SEL_W-1:0] trip_sel,
  input  logic             ext_rst_req,
  input  logic             acc_start,
  input  logic             acc_done,
  output logic             rst_n_o,
  output logic             bus_lock,
  output logic             rel_pulse,
  output logic             acc_inflight
);
  lvl_vec_t flags_s;
  logic     fault;
  logic     hold;
  logic     want_rst;

  lsr_sync #(.WIDTH(LVL_N), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst(rst), .d(below_flags), .q(flags_s));

  lsr_level_pick u_pick (.flags_s(flags_s), .sel(trip_sel), .fault(fault));

  lsr_hold_timer #(.HOLD_TICKS(HOLD_TICKS)) u_hold (
    .clk(clk), .rst(rst), .fault(fault), .tick(tick_1ms), .hold(hold));

  assign want_rst = hold | ext_rst_req;

  always_ff @(posedge clk) begin
    if (rst) begin
      rst_n_o   <= 1'b0;
      bus_lock  <= 1'b1;
      rel_pulse <= 1'b0;
    end else begin
      rst_n_o   <= ~want_rst;
      bus_lock  <= want_rst;
      rel_pulse <= ~rst_n_o & ~want_rst;
    end
  end

  lsr_bus_guard u_guard (
    .clk(clk), .rst(rst), .locked(bus_lock), .start(acc_start),
    .done(acc_done), .inflight(acc_inflight));

  // R3: a seen fault reaches the pin through hold
  p_fault_to_pin_r3: assert property (@(posedge clk) disable iff (rst)
    fault |=> ##1 !rst_n_o);
  // R8: external request asserts reset on the next edge
  p_ext_merge_r8: assert property (@(posedge clk) disable iff (rst)
    ext_rst_req |=> !rst_n_o);
  // R9: release pulse only at a rising reset output
  p_pulse_on_rise_r9: assert property (@(posedge clk) disable iff (rst)
    rel_pulse |-> (rst_n_o && !$past(rst_n_o)));
  p_pulse_single_r9: assert property (@(posedge clk) disable iff (rst)
    rel_pulse |=> !rel_pulse);
  // R10: lock mirrors reset
  p_lock_mirror_r10: assert property (@(posedge clk) disable iff (rst)
    bus_lock != rst_n_o);
endmodule

// File: tb/sim_lsr_seq.sv
module sim_lsr_seq;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_1ms = 1'b1;
  logic [3:0] below_flags = 4'b0000;
  logic [1:0] trip_sel = 2'd0;
  logic ext_rst_req = 1'b0;
  logic acc_start = 1'b0;
  logic acc_done = 1'b0;
  logic rst_n_o, bus_lock, rel_pulse, acc_inflight;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  lsr_seq u0 (
    .clk(clk), .rst(rst), .tick_1ms(tick_1ms), .below_flags(below_flags),
    .trip_sel(trip_sel), .ext_rst_req(ext_rst_req), .acc_start(acc_start),
    .acc_done(acc_done), .rst_n_o(rst_n_o), .bus_lock(bus_lock),
    .rel_pulse(rel_pulse), .acc_inflight(acc_inflight));

  // {sel[1:0], flags[3:0], expected rst_n}
  localparam logic [6:0] VEC [8] = '{
    {2'd0, 4'b0001, 1'b0}, {2'd0, 4'b1110, 1'b1},
    {2'd1, 4'b0010, 1'b0}, {2'd1, 4'b1101, 1'b1},
    {2'd2, 4'b0100, 1'b0}, {2'd2, 4'b1011, 1'b1},
    {2'd3, 4'b1000, 1'b0}, {2'd3, 4'b0111, 1'b1}};

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic measure(output int edges);
    edges = 0;
    for (int i = 1; i <= 400; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (rst_n_o) begin
        edges = i;
        break;
      end
    end
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int e;
    @(negedge clk);
    step(3);
    check("R1 rst_n", rst_n_o, 0);
    check("R1 bus_lock", bus_lock, 1);
    check("R1 rel_pulse", rel_pulse, 0);
    check("R1 inflight", acc_inflight, 0);

    rst = 1'b0;
    measure(e);
    check("R7 power-up hold edges", e, 103);
    check("R9 pulse on release", rel_pulse, 1);
    step(1);
    check("R9 pulse one cycle", rel_pulse, 0);

    // vector table: trip-select
    for (int v = 0; v < 8; v++) begin
      trip_sel = VEC[v][6:5];
      below_flags = VEC[v][4:1];
      step(110);
      check($sformatf("R2 vec%0d", v), rst_n_o, VEC[v][0]);
    end
    trip_sel = 2'd0; below_flags = 4'b0000;
    step(110);

    // R3 latency
    below_flags[0] = 1'b1;
    step(3);
    check("R3 still high after edge 3", rst_n_o, 1);
    step(1);
    check("R3 low after edge 4", rst_n_o, 0);
    check("R10 lock follows reset", bus_lock, 1);
    step(6);
    below_flags[0] = 1'b0;
    measure(e);
    check("R4 hold edges", e, 103);

    // R5 ticks gate the count
    below_flags[0] = 1'b1;
    step(10);
    tick_1ms = 1'b0;
    below_flags[0] = 1'b0;
    step(200);
    check("R5 no ticks keeps reset", rst_n_o, 0);
    tick_1ms = 1'b1;
    measure(e);
    check("R5 release after ticks", e, 101);

    // R6 restart during count
    below_flags[0] = 1'b1;
    step(10);
    below_flags[0] = 1'b0;
    step(50);
    check("R6 counting still low", rst_n_o, 0);
    below_flags[0] = 1'b1;
    step(10);
    below_flags[0] = 1'b0;
    measure(e);
    check("R6 full hold again", e, 103);

    // R8 external request
    ext_rst_req = 1'b1;
    step(1);
    check("R8 ext asserts", rst_n_o, 0);
    step(5);
    ext_rst_req = 1'b0;
    step(1);
    check("R8 ext release", rst_n_o, 1);
    check("R9 pulse on ext release", rel_pulse, 1);

    // R10/R11 bus lockout
    acc_start = 1'b1;
    step(1);
    acc_start = 1'b0;
    check("R11 accepted", acc_inflight, 1);
    below_flags[0] = 1'b1;
    step(10);
    check("R10 locked", bus_lock, 1);
    check("R11 inflight kept", acc_inflight, 1);
    acc_done = 1'b1;
    step(1);
    acc_done = 1'b0;
    check("R11 done clears", acc_inflight, 0);
    acc_start = 1'b1;
    step(1);
    acc_start = 1'b0;
    check("R10 start ignored when locked", acc_inflight, 0);
    below_flags[0] = 1'b0;
    measure(e);
    check("R4 final release", e, 103);

    finished = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule